// File: doc/BRIEF.md
# Write-Verify Pulse Loop Controller

This block sequences the programming of one resistive cell in one partition of a cross-point array. When the array sequencer raises `go_i`, the controller drives the addressed cell with a train of slots. Verify (read) slots and write slots strictly alternate, and the train always opens with a verify slot. During each verify slot the controller strobes the external comparator's verdict in the last driven cycle. If the sensed current already meets the target, the controller issues a one-cycle acknowledge and stops without another write. If the current falls short, the controller completes the verify slot and then applies a write slot at the higher level.

Slot length and the driven width of read and write pulses are programmable in clock cycles, which sets the pulse frequency and the duty cycle. Every slot ends with at least one undriven cycle, so the line returns to mid-supply bias between pulses. A programmable ceiling on write pulses guarantees termination. A verify that misses after the last allowed write acknowledges anyway with a timeout flag. Dropping `go_i` while a train is running abandons it without an acknowledge.

Top module: `wv_pulse_ctrl`

## Requirements
- R1: Out of reset, and while idle, all outputs are low. After `go_i` is seen high at a clock edge in idle, the following cycle is the first cycle of a verify slot: `drive_en_o`=1 and `level_sel_o`=0. A train never opens with a write.
- R2: Every slot lasts Pe = max(`cfg_period_i`, 2) cycles. `drive_en_o` is high for the first `on` cycles of the slot and low for the rest. Here on = 1 if the programmed width is 0, on = Pe-1 if the width is at least Pe, and the width itself otherwise. The programmed width is `cfg_rd_len_i` for verify slots and `cfg_wr_len_i` for write slots.
- R3: `level_sel_o` is 0 (read level) throughout verify slots and 1 (write level) throughout write slots. It is 0 when not in a slot.
- R4: `sample_o` is high for exactly one cycle per verify slot, in that slot's last driven cycle. It is never high in a write slot.
- R5: If `cmp_met_i` is 1 in a sample cycle, the next cycle has `ack_o`=1 for exactly one cycle with `drive_en_o`=0 and `timeout_o`=0. The block is idle afterwards and issues no further write.
- R6: If `cmp_met_i` is 0 in a sample cycle and fewer than `cfg_max_wr_i` writes have been issued in this train, the verify slot runs to its end and a write slot follows immediately.
- R7: If `cmp_met_i` is 0 in a sample cycle and `cfg_max_wr_i` writes have already been issued, the next cycle has `ack_o`=1 and `timeout_o`=1 together. `timeout_o` is never high without `ack_o`.
- R8: If `go_i` is low at an edge during a verify or write slot, the next cycle is idle: `drive_en_o`=0. No acknowledge follows.
- R9: If `go_i` is still high after an acknowledge, a new train starts one idle cycle later with its write count cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Sequencer request; a train runs while high |
| cmp_met_i | input | 1 | Comparator verdict: sensed current meets target |
| cfg_period_i | input | CNT_W | Slot length in cycles (minimum 2 applied) |
| cfg_rd_len_i | input | CNT_W | Driven width of a verify pulse |
| cfg_wr_len_i | input | CNT_W | Driven width of a write pulse |
| cfg_max_wr_i | input | PC_W | Maximum write pulses per train |
| drive_en_o | output | 1 | Analogue driver enable; low means mid-supply bias |
| level_sel_o | output | 1 | 0 = read level, 1 = write level |
| sample_o | output | 1 | Comparator sampling strobe |
| ack_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Qualifies `ack_o`: write ceiling reached |

## Verification
The bench sweeps slot lengths, pulse widths, comparator success points and write ceilings, including zero widths, widths at or past the slot length, and a ceiling of zero. An off-by-one in the width clamp would drive a slot with no undriven tail or shift the sample strobe. A design that decided at the end of the verify slot rather than at the sample point would acknowledge late. An off-by-one ceiling would issue one write too many or too few before the timeout. Directed runs drop `go_i` mid-write to catch a spurious acknowledge. Back-to-back trains with `go_i` held show whether a stale write count shortens the second train.

// File: rtl/wv_pkg.sv
package wv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_ACK   = 2'd3
  } wv_state_e;

  localparam logic LVL_READ  = 1'b0;
  localparam logic LVL_WRITE = 1'b1;

  // Slot length in cycles: at least two so a slot always has an undriven tail.
  function automatic int unsigned slot_cycles(input int unsigned period);
    return (period < 32'd2) ? 32'd2 : period;
  endfunction

  // Driven cycles inside a slot: at least one, at most one less than the slot.
  function automatic int unsigned on_cycles(input int unsigned len, input int unsigned slot);
    if (len == 32'd0) return 32'd1;
    if (len >= slot) return slot - 32'd1;
    return len;
  endfunction

endpackage

// File: rtl/wv_phase_timer.sv
module wv_phase_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             is_write_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] rd_len_i,
  input  logic [CNT_W-1:0] wr_len_i,
  output logic             pulse_on_o,
  output logic             sample_pt_o,
  output logic             slot_last_o
);
  import wv_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] slot_len;
  logic [CNT_W-1:0] on_len;
  logic [CNT_W-1:0] raw_len;

  assign raw_len  = is_write_i ? wr_len_i : rd_len_i;
  assign slot_len = CNT_W'(slot_cycles(32'(period_i)));
  assign on_len   = CNT_W'(on_cycles(32'(raw_len), 32'(slot_len)));

  assign slot_last_o = (cnt_q == slot_len - CNT_W'(1));
  assign pulse_on_o  = (cnt_q < on_len);
  assign sample_pt_o = (cnt_q == on_len - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (slot_last_o) cnt_q <= '0;
    else                  cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/wv_write_counter.sv
module wv_write_counter #(
  parameter int unsigned PC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            inc_i,
  input  logic [PC_W-1:0] max_i,
  output logic            at_limit_o
);
  logic [PC_W-1:0] cnt_q;

  assign at_limit_o = (cnt_q >= max_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (clear_i)              cnt_q <= '0;
    else if (inc_i && !at_limit_o) cnt_q <= cnt_q + PC_W'(1);
  end

endmodule

// File: rtl/wv_seq_fsm.sv
module wv_seq_fsm (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              cmp_met_i,
  input  logic              sample_pt_i,
  input  logic              slot_last_i,
  input  logic              at_limit_i,
  output wv_pkg::wv_state_e state_o,
  output logic              timeout_q_o
);
  import wv_pkg::*;

  wv_state_e st_q, st_d;
  logic      decide;

  assign decide = (st_q == ST_READ) && go_i && sample_pt_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (go_i) st_d = ST_READ;
      ST_READ: begin
        if (!go_i)                                      st_d = ST_IDLE;
        else if (sample_pt_i && (cmp_met_i || at_limit_i)) st_d = ST_ACK;
        else if (slot_last_i)                           st_d = ST_WRITE;
      end
      ST_WRITE: begin
        if (!go_i)            st_d = ST_IDLE;
        else if (slot_last_i) st_d = ST_READ;
      end
      ST_ACK:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      timeout_q_o <= 1'b0;
    end else begin
      st_q <= st_d;
      if (decide) timeout_q_o <= !cmp_met_i && at_limit_i;
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/wv_pulse_ctrl.sv
module wv_pulse_ctrl #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PC_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic             cmp_met_i,
  input  logic [CNT_W-1:0] cfg_period_i,
  input  logic [CNT_W-1:0] cfg_rd_len_i,
  input  logic [CNT_W-1:0] cfg_wr_len_i,
  input  logic [PC_W-1:0]  cfg_max_wr_i,
  output logic             drive_en_o,
  output logic             level_sel_o,
  output logic             sample_o,
  output logic             ack_o,
  output logic             timeout_o
);
  import wv_pkg::*;

  wv_state_e state_w;
  logic      in_read_w, in_write_w, busy_w;
  logic      pulse_on_w, sample_pt_w, slot_last_w;
  logic      at_limit_w, timeout_q_w;
  logic      wr_done_w;

  assign in_read_w  = (state_w == ST_READ);
  assign in_write_w = (state_w == ST_WRITE);
  assign busy_w     = in_read_w || in_write_w;
  assign wr_done_w  = in_write_w && go_i && slot_last_w;

  wv_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (busy_w),
    .is_write_i (in_write_w),
    .period_i   (cfg_period_i),
    .rd_len_i   (cfg_rd_len_i),
    .wr_len_i   (cfg_wr_len_i),
    .pulse_on_o (pulse_on_w),
    .sample_pt_o(sample_pt_w),
    .slot_last_o(slot_last_w)
  );

  wv_write_counter #(.PC_W(PC_W)) u_wcnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (!busy_w),
    .inc_i     (wr_done_w),
    .max_i     (cfg_max_wr_i),
    .at_limit_o(at_limit_w)
  );

  wv_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (go_i),
    .cmp_met_i  (cmp_met_i),
    .sample_pt_i(sample_pt_w),
    .slot_last_i(slot_last_w),
    .at_limit_i (at_limit_w),
    .state_o    (state_w),
    .timeout_q_o(timeout_q_w)
  );

  assign drive_en_o  = busy_w && pulse_on_w;
  assign level_sel_o = in_write_w ? LVL_WRITE : LVL_READ;
  assign sample_o    = in_read_w && sample_pt_w;
  assign ack_o       = (state_w == ST_ACK);
  assign timeout_o   = ack_o && timeout_q_w;

endmodule

module wv_pulse_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic go_i,
  input logic cmp_met_i,
  input logic drive_en_o,
  input logic level_sel_o,
  input logic sample_o,
  input logic ack_o,
  input logic timeout_o,
  input logic busy_w
);
  p_level_swap_undriven_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(level_sel_o) && busy_w) |-> !$past(drive_en_o));
  p_sample_in_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> (drive_en_o && !level_sel_o));
  p_met_acks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_o && cmp_met_i && go_i) |=> (ack_o && !timeout_o));
  p_ack_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);
  p_ack_undriven_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> !drive_en_o);
  p_timeout_with_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> ack_o);
  p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && !go_i) |=> (!drive_en_o && !ack_o));
endmodule

bind wv_pulse_ctrl wv_pulse_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .go_i       (go_i),
  .cmp_met_i  (cmp_met_i),
  .drive_en_o (drive_en_o),
  .level_sel_o(level_sel_o),
  .sample_o   (sample_o),
  .ack_o      (ack_o),
  .timeout_o  (timeout_o),
  .busy_w     (busy_w)
);

// File: tb/sim_wv_pulse_ctrl.sv
`timescale 1ns/1ps
module sim_wv_pulse_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       go = 1'b0;
  logic       cmp = 1'b0;
  logic [7:0] period = 8'd2, rdl = 8'd1, wrl = 8'd1, maxw = 8'd0;
  logic       en, lvl, smp, ack, tmo;
  int         n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  wv_pulse_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .go_i(go), .cmp_met_i(cmp),
    .cfg_period_i(period), .cfg_rd_len_i(rdl), .cfg_wr_len_i(wrl), .cfg_max_wr_i(maxw),
    .drive_en_o(en), .level_sel_o(lvl), .sample_o(smp), .ack_o(ack), .timeout_o(tmo)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b (P=%0d rd=%0d wr=%0d max=%0d t=%0t)",
               tag, what, act, exp, period, rdl, wrl, maxw, $time);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, "drive_en", en, 1'b0);
    chk(tag, "level", lvl, 1'b0);
    chk(tag, "sample", smp, 1'b0);
    chk(tag, "ack", ack, 1'b0);
    chk(tag, "timeout", tmo, 1'b0);
  endtask

  // Starts at a negedge with the block idle; cmp becomes high from read slot k onward.
  task automatic run_seq(input int p, input int rd, input int wr, input int k, input int m,
                         input int abort_at, input bit keep, input string atag);
    int pe, ron, won, s, slot, pos;
    bit late, rslot;
    pe   = (p < 2) ? 2 : p;
    ron  = (rd == 0) ? 1 : ((rd >= pe) ? pe - 1 : rd);
    won  = (wr == 0) ? 1 : ((wr >= pe) ? pe - 1 : wr);
    late = (k > m);
    s    = ((k <= m) ? k : m) * 2 * pe + ron;
    period = 8'(p); rdl = 8'(rd); wrl = 8'(wr); maxw = 8'(m);
    go = 1'b1; cmp = 1'b0;
    for (int i = 0; i <= s; i++) begin
      @(negedge clk);
      cmp = (i >= k * 2 * pe);
      if (i < s) begin
        slot  = i / pe;
        pos   = i % pe;
        rslot = (slot % 2 == 0);
        if (i == 0) chk("R1", "first slot is driven read", en && !lvl, 1'b1);
        chk("R2", "drive_en", en, pos < (rslot ? ron : won));
        chk(rslot ? "R3" : "R6", "level", lvl, !rslot);
        chk("R4", "sample", smp, rslot && (pos == ron - 1));
        chk(atag, "ack", ack, 1'b0);
        chk("R7", "timeout", tmo, 1'b0);
      end else begin
        chk(atag, "ack", ack, 1'b1);
        chk(atag, "drive_en at ack", en, 1'b0);
        chk("R7", "timeout", tmo, late);
      end
      if (i == abort_at) begin
        go = 1'b0;
        break;
      end
      if (i == s && !keep) go = 1'b0;
    end
    for (int j = 0; j < (keep ? 1 : 3); j++) begin
      @(negedge clk);
      chk_idle((abort_at >= 0) ? "R8" : atag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int ps[4] = '{0, 2, 3, 5};
    int ls[4] = '{0, 1, 2, 7};
    int ws[4] = '{0, 1, 4, 9};
    int ks[3] = '{0, 1, 3};
    int ms[2] = '{0, 2};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk_idle("R1");
    end
    foreach (ps[a]) foreach (ls[b]) foreach (ws[c]) foreach (ks[d]) foreach (ms[e])
      run_seq(ps[a], ls[b], ws[c], ks[d], ms[e], -1, 1'b0, "R5");
    // R8: abort inside a write slot and inside a read slot
    run_seq(4, 2, 3, 5, 5, 5, 1'b0, "R5");
    run_seq(3, 1, 1, 5, 5, 6, 1'b0, "R5");
    run_seq(2, 0, 0, 9, 9, 3, 1'b0, "R5");
    // R9: back-to-back trains with go held; second must use a fresh write count
    run_seq(3, 1, 2, 9, 2, -1, 1'b1, "R9");
    run_seq(3, 1, 2, 9, 2, -1, 1'b1, "R9");
    run_seq(4, 2, 1, 1, 3, -1, 1'b0, "R9");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule